// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM read or write burst. A start pulse loads the starting column together with the burst settings (length, wrap order, access direction and a single-beat-write option). From the next cycle on, the block presents one column per cycle until the burst ends, with a beat-valid strobe and a flag on the final beat.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column. They walk through that block either by incrementing or by XOR-ing the beat number into the low bits. A full-page burst walks the whole row, wrapping at the top, until a terminate input stops it. A new start may arrive on any cycle, including during a burst, and the new burst then begins on the next cycle. The burst settings are captured at the start pulse, so changes to the mode inputs during a burst have no effect on it.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While rst_ni is low, beat_valid_o and last_o are 0.
- R2: A start_i sampled high at a rising edge makes beat_valid_o 1 and col_o equal to the sampled start_col_i for the cycle that follows that edge.
- R3: bl_code_i selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and 4 to 6 give 1 beat. After the final beat, beat_valid_o is 0 unless a new start was sampled.
- R4: With wrap_ilv_i = 0 and a fixed length L, beat k shows the start column with its low log2(L) bits replaced by (start + k) mod L. The upper bits are unchanged.
- R5: With wrap_ilv_i = 1 and a fixed length L, beat k shows the start column XOR k, where k < L.
- R6: In a full-page burst, beat k shows (start + k) mod 1024. The burst never ends by itself and wrap_ilv_i has no effect.
- R7: last_o is 1 exactly on the final beat of a fixed-length burst and is never 1 in a full-page burst.
- R8: term_i sampled high at an edge with start_i low ends the burst, so beat_valid_o is 0 in the following cycle.
- R9: A start during a burst discards the old burst. The next cycle shows beat 0 of the new burst with its own settings, and start takes priority over term_i.
- R10: When is_write_i = 1 and single_wr_i = 1 at start, the burst has exactly one beat with last_o = 1, whatever bl_code_i says.
- R11: Changes to bl_code_i, wrap_ilv_i, is_write_i and single_wr_i while no start is sampled do not alter the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command pulse: load a new burst |
| start_col_i | input | 10 | Starting column |
| bl_code_i | input | 3 | Burst length code |
| wrap_ilv_i | input | 1 | 0 sequential, 1 interleave |
| is_write_i | input | 1 | Command is a write |
| single_wr_i | input | 1 | Writes are single-beat when set |
| term_i | input | 1 | Stop the current burst |
| col_o | output | 10 | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Current beat is the final one |

## Verification
Every output is driven from state that is registered at the rising edge. A start, terminate or final beat sampled at edge N therefore shows on col_o, beat_valid_o and last_o in the cycle after edge N, and not earlier. The bench updates its own burst model at each rising edge from the inputs it held stable across that edge. It then compares the outputs 1 ns later and drives the next inputs only after that comparison. The expected result of each stimulus is therefore checked in exactly the cycle it is due.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;
  typedef enum logic [2:0] {
    BL_ONE  = 3'd0,
    BL_TWO  = 3'd1,
    BL_FOUR = 3'd2,
    BL_EIGHT= 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;
endpackage

// File: rtl/sbcg_mode_dec.sv
module sbcg_mode_dec import sbcg_pkg::*; #(
  parameter int COL_W = 10
) (
  input  logic [2:0]       bl_code_i,
  input  logic             wrap_ilv_i,
  input  logic             is_write_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o
);
  logic single_beat;
  assign single_beat = is_write_i && single_wr_i;

  always_comb begin
    full_o = 1'b0;
    mask_o = '0;
    if (!single_beat) begin
      case (bl_code_i)
        BL_TWO:   mask_o = COL_W'(1);
        BL_FOUR:  mask_o = COL_W'(3);
        BL_EIGHT: mask_o = COL_W'(7);
        BL_PAGE: begin
          mask_o = '1;
          full_o = 1'b1;
        end
        default:  mask_o = '0;
      endcase
    end
  end

  // full page always runs sequential
  assign ilv_o = wrap_ilv_i && !full_o;
endmodule

// File: rtl/sbcg_beat_ctl.sv
module sbcg_beat_ctl #(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic             active_o,
  output logic             last_o
);
  logic             active_q;
  logic [COL_W-1:0] cnt_q, base_q, mask_q;
  logic             full_q, ilv_q;

  assign last_o = active_q && !full_q && (cnt_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      base_q   <= start_col_i;
      mask_q   <= mask_i;
      full_q   <= full_i;
      ilv_q    <= ilv_i;
    end else if (active_q) begin
      if (term_i || last_o) active_q <= 1'b0;
      else                  cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign base_o   = base_q;
  assign cnt_o    = cnt_q;
  assign mask_o   = mask_q;
  assign full_o   = full_q;
  assign ilv_o    = ilv_q;
  assign active_o = active_q;

  // R3
  last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !active_q);
  // R4
  cnt_in_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !full_q |-> (cnt_q & ~mask_q) == '0);
  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !start_i |=> $stable(mask_q) && $stable(base_q) && $stable(ilv_q));
endmodule

// File: rtl/sbcg_addr_gen.sv
module sbcg_addr_gen #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_low, ilv_low;
  assign seq_low = base_i + cnt_i;
  assign ilv_low = base_i ^ cnt_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (ilv_i ? ilv_low[i] : seq_low[i]) : base_i[i];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             wrap_ilv_i,
  input  logic             is_write_i,
  input  logic             single_wr_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask, base, cnt, mask;
  logic             dec_full, dec_ilv, full, ilv, active;

  sbcg_mode_dec #(.COL_W(COL_W)) u_dec (
    .bl_code_i(bl_code_i), .wrap_ilv_i(wrap_ilv_i), .is_write_i(is_write_i),
    .single_wr_i(single_wr_i), .mask_o(dec_mask), .full_o(dec_full), .ilv_o(dec_ilv)
  );

  sbcg_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .term_i(term_i),
    .start_col_i(start_col_i), .mask_i(dec_mask), .full_i(dec_full), .ilv_i(dec_ilv),
    .base_o(base), .cnt_o(cnt), .mask_o(mask), .full_o(full), .ilv_o(ilv),
    .active_o(active), .last_o(last_o)
  );

  sbcg_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i(base), .cnt_i(cnt), .mask_i(mask), .ilv_i(ilv), .col_o(col_o)
  );

  assign beat_valid_o = active;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> !beat_valid_o && !last_o);
  // R2
  first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> beat_valid_o && col_o == $past(start_col_i));
  // R8
  term_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i && !start_i |=> !beat_valid_o);
  // R7
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> beat_valid_o && !full);
  // R6
  page_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && full && !start_i && !term_i |=> col_o == $past(col_o) + 1'b1);
  // R4
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !last_o && !start_i && !term_i |=> (col_o & ~mask) == ($past(col_o) & ~mask));
endmodule

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;
  logic       clk = 0, rst_n = 0;
  logic       start = 0, ilv = 0, wr = 0, sw = 0, term = 0;
  logic [9:0] scol = 0;
  logic [2:0] bl = 0;
  logic [9:0] col;
  logic       valid, last;

  int errors = 0, checks = 0;
  string focus = "";

  // bench model
  int m_act = 0, m_k = 0, m_base = 0, m_len = 1, m_ilv = 0;
  string m_tag = "R4";

  always #4 clk = ~clk;

  sdram_burst_colgen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .bl_code_i(bl), .wrap_ilv_i(ilv), .is_write_i(wr), .single_wr_i(sw),
    .term_i(term), .col_o(col), .beat_valid_o(valid), .last_o(last)
  );

  function automatic int len_of(input int code, input bit w, input bit s);
    if (w && s) return 1;
    case (code)
      0: return 1; 1: return 2; 2: return 4; 3: return 8; 7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int b, input int k, input int l, input int il);
    if (l == 0) return (b + k) % 1024;
    if (il != 0) return b ^ k;
    return (b & ~(l - 1)) | ((b + k) & (l - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    string t;
    t = (focus != "") ? focus : "R3";
    chk(valid == (m_act != 0), t, valid, m_act);
    if (m_act != 0) begin
      int e;
      bit el;
      e  = exp_col(m_base, m_k, m_len, m_ilv);
      el = (m_len != 0) && (m_k == m_len - 1);
      t = (focus != "") ? focus : ((m_k == 0) ? "R2" : m_tag);
      chk(col == 10'(e), t, col, e);
      t = (focus != "") ? focus : "R7";
      chk(last == el, t, last, el);
    end else begin
      chk(last == 1'b0, (focus != "") ? focus : "R7", last, 0);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (start) begin
      m_act = 1; m_k = 0; m_base = scol;
      m_len = len_of(bl, wr, sw);
      m_ilv = (m_len == 0) ? 0 : ilv;
      m_tag = (wr && sw) ? "R10" : (m_len == 0) ? "R6" : (m_ilv != 0) ? "R5" : "R4";
    end else if (m_act != 0) begin
      if (term || (m_len != 0 && m_k == m_len - 1)) m_act = 0;
      else m_k = (m_k + 1) % 1024;
    end
    #1;
    compare();
  endtask

  task automatic go(input int c, input int b, input bit i, input bit w, input bit s);
    start = 1; scol = 10'(c); bl = 3'(b); ilv = i; wr = w; sw = s; term = 0;
    tick();
    start = 0;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) tick();
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20;
    chk(valid == 0 && last == 0, "R1", {valid, last}, 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    // R2 R4: sequential 8 from an unaligned start near the top
    go(10'h3F5, 3, 0, 0, 0); idle(9);
    // R5: interleave 4
    go(10'h12E, 2, 1, 0, 0); idle(5);
    go(10'h0A5, 3, 1, 1, 0); idle(9);
    // R6: full page crossing the top, then terminate (R8)
    go(10'h3FE, 7, 1, 0, 0); idle(6);
    focus = "R8"; term = 1; tick(); term = 0; idle(2); focus = "";
    // R3: reserved code gives one beat
    go(10'h055, 5, 0, 0, 0); idle(2);
    go(10'h200, 1, 0, 0, 0); idle(3);
    // R9: restart mid-burst, start beats term
    go(10'h100, 3, 0, 0, 0); idle(2);
    focus = "R9"; term = 1; go(10'h2C3, 2, 1, 0, 0); term = 0; idle(5); focus = "";
    // R10: single-beat write despite length 8; reads still burst
    go(10'h017, 3, 0, 1, 1); idle(2);
    go(10'h017, 3, 0, 0, 1); idle(9);
    // R11: mode inputs change mid-burst
    go(10'h064, 3, 0, 0, 0);
    focus = "R11"; bl = 7; ilv = 1; wr = 1; sw = 1; idle(9); focus = "";
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 5);
      start = ($urandom_range(0, 3) == 0);
      scol  = 10'($urandom_range(0, 1023));
      bl    = (r == 4) ? 3'd7 : (r == 5) ? 3'($urandom_range(4, 6)) : 3'(r);
      ilv   = 1'($urandom_range(0, 1));
      wr    = 1'($urandom_range(0, 1));
      sw    = ($urandom_range(0, 3) == 0);
      term  = ($urandom_range(0, 15) == 0);
      tick();
    end
    start = 0; term = 0; idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial void'($urandom(32'h5D2A));
endmodule